// File: doc/BRIEF.md
# Register Bit-Field Extractor

This unit pulls a bit field of 1 to 32 bits out of a 32-bit data register and returns it right-justified in a 32-bit result. Depending on one opcode bit, the upper bits are filled with zeros or with copies of the field's top bit. The field's start position is counted from the most significant bit: offset 0 names bit 31. A field that runs past bit 0 continues at bit 31. The width and the offset can each come from the extension word or from a data register.

The unit sits beside an eight-entry register file. It drives three read addresses and takes back the data of each one in the same cycle:
- the source register, indexed by opcode bits [2:0];
- the width register, indexed by extension bits [2:0];
- the offset register, indexed by extension bits [8:6].

One cycle after an accepted request, the unit presents the result, the destination index, a write enable and the N/Z/V/C condition flags.

Top module: `bfx_unit`

## Requirements
- R1: A request is legal when (opWord AND 0xFDF8) equals 0xE9C0. Any other opWord with inValid high produces illegal=1 and wrEn=0 in the following cycle.
- R2: When extWord bit 5 is 0, the width is extWord[4:0], and a code of 0 means 32 bits.
- R3: When extWord bit 11 is 0, the offset is extWord[10:6]. Offset k places the first (most significant) field bit at source bit 31-k.
- R4: When extWord bit 5 is 1, the width is the low 5 bits of the register addressed by extWord[2:0]. Its upper bits are ignored, and a code of 0 again means 32.
- R5: When extWord bit 11 is 1, the offset is the register addressed by extWord[8:6], taken modulo 32. In this mode extWord[10:9] are ignored.
- R6: Field bits that fall below bit 0 continue from bit 31 downward, as if the source were rotated left by the offset.
- R7: opWord bit 9 = 1 sign-extends the field into the 32-bit result, and bit 9 = 0 zero-extends it.
- R8: flagN equals the most significant bit of the field. flagZ is 1 exactly when every field bit is 0. flagV and flagC are 0.
- R9: outValid is high exactly in the cycle after inValid. wrEn is high in that cycle for a legal request.
- R10: An illegal request leaves result and all four flags at their previous values.
- R11: After reset, outValid, wrEn, illegal, result, dstIdx and all flags are 0.
- R12: The source register is addressed by opWord[2:0] and the destination index output is extWord[14:12], loaded on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opWord | input | 16 | Opcode word |
| extWord | input | 16 | Extension word |
| srcAddr | output | 3 | Register file read address for the source operand |
| widAddr | output | 3 | Register file read address for the width register |
| ofsAddr | output | 3 | Register file read address for the offset register |
| srcData | input | 32 | Source register contents |
| widData | input | 32 | Width register contents |
| ofsData | input | 32 | Offset register contents |
| outValid | output | 1 | Result cycle marker |
| wrEn | output | 1 | Destination write enable |
| illegal | output | 1 | Unrecognised opcode indication |
| dstIdx | output | 3 | Destination register index |
| result | output | 32 | Extended field |
| flagN | output | 1 | Field sign bit |
| flagZ | output | 1 | Field is all zeros |
| flagV | output | 1 | Overflow, always cleared |
| flagC | output | 1 | Carry, always cleared |

## Verification
The hardest cases are the wrapping fields. These are the cases where the offset plus the width exceeds 32, most of all when the width or the offset is taken from a register whose upper bits hold garbage. The bench reaches them by sweeping every width code against every offset in all four source combinations (immediate or register for each of width and offset), with sign and zero extension alternating. It loads the width and offset registers with junk above the low five bits and sets the ignored extension bits. A bit-by-bit model in the bench provides the expected result and flags. Illegal opcodes are issued directly after a legal one, to show that the visible result and flags hold.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  // Strobes from decode to datapath
  typedef struct packed {
    logic legal;
    logic widFromReg;
    logic ofsFromReg;
    logic signExt;
  } bfx_ctrl_t;
endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
(
  input  logic [15:0]      opWord,
  input  logic [15:0]      extWord,
  output logic [IDX_W-1:0] srcAddr,
  output logic [IDX_W-1:0] widAddr,
  output logic [IDX_W-1:0] ofsAddr,
  output logic [IDX_W-1:0] dstSel,
  output bfx_ctrl_t        ctrl
);
  localparam logic [15:0] MATCH_MASK = 16'hFDF8;
  localparam logic [15:0] MATCH_VAL  = 16'hE9C0;

  always_comb begin
    ctrl.legal      = (opWord & MATCH_MASK) == MATCH_VAL;
    ctrl.widFromReg = extWord[5];
    ctrl.ofsFromReg = extWord[11];
    ctrl.signExt    = opWord[9];
    srcAddr = opWord[2:0];
    widAddr = extWord[2:0];
    ofsAddr = extWord[8:6];
    dstSel  = extWord[14:12];
  end
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  bfx_ctrl_t        ctrl,
  input  logic [4:0]       immWid,
  input  logic [4:0]       immOfs,
  input  logic [IDX_W-1:0] dstSel,
  input  logic [DW-1:0]    srcData,
  input  logic [DW-1:0]    widData,
  input  logic [DW-1:0]    ofsData,
  output logic             outValid,
  output logic             wrEn,
  output logic             illegal,
  output logic [IDX_W-1:0] dstIdx,
  output logic [DW-1:0]    result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC
);
  localparam int unsigned LW = $clog2(DW);

  logic [LW-1:0]   widCode, ofsAmt;
  logic [LW:0]     fieldLen, shAmt;
  logic [2*DW-1:0] dbl;
  logic [DW-1:0]   rotated, zeroField, signField;

  always_comb begin
    widCode  = ctrl.widFromReg ? widData[LW-1:0] : immWid[LW-1:0];
    ofsAmt   = ctrl.ofsFromReg ? ofsData[LW-1:0] : immOfs[LW-1:0];
    fieldLen = (widCode == '0) ? (LW+1)'(DW) : {1'b0, widCode};
    shAmt    = (LW+1)'(DW) - fieldLen;
    dbl      = {srcData, srcData} << ofsAmt;
    rotated  = dbl[2*DW-1:DW];
    zeroField = rotated >> shAmt;
    signField = DW'($signed(rotated) >>> shAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wrEn     <= 1'b0;
      illegal  <= 1'b0;
      dstIdx   <= '0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
    end else begin
      outValid <= inValid;
      wrEn     <= inValid & ctrl.legal;
      illegal  <= inValid & ~ctrl.legal;
      if (inValid) dstIdx <= dstSel;
      if (inValid && ctrl.legal) begin
        result <= ctrl.signExt ? signField : zeroField;
        flagN  <= rotated[DW-1];
        flagZ  <= (zeroField == '0);
        flagV  <= 1'b0;
        flagC  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] opWord,
  input  logic [15:0] extWord,
  output logic [2:0]  srcAddr,
  output logic [2:0]  widAddr,
  output logic [2:0]  ofsAddr,
  input  logic [31:0] srcData,
  input  logic [31:0] widData,
  input  logic [31:0] ofsData,
  output logic        outValid,
  output logic        wrEn,
  output logic        illegal,
  output logic [2:0]  dstIdx,
  output logic [31:0] result,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagV,
  output logic        flagC
);
  bfx_ctrl_t ctrl;
  logic [IDX_W-1:0] dstSel;

  bfx_ctrl uCtrl (
    .opWord(opWord), .extWord(extWord),
    .srcAddr(srcAddr), .widAddr(widAddr), .ofsAddr(ofsAddr),
    .dstSel(dstSel), .ctrl(ctrl)
  );

  bfx_datapath #(.DW(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl),
    .immWid(extWord[4:0]), .immOfs(extWord[10:6]), .dstSel(dstSel),
    .srcData(srcData), .widData(widData), .ofsData(ofsData),
    .outValid(outValid), .wrEn(wrEn), .illegal(illegal), .dstIdx(dstIdx),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [15:0] extWord,
  input logic        outValid,
  input logic        wrEn,
  input logic        illegal,
  input logic [2:0]  dstIdx,
  input logic [31:0] result,
  input logic        flagN,
  input logic        flagZ
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_outcome_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot({wrEn, illegal}));
  p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || illegal) |-> outValid);
  p_hold_on_illegal_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> ($stable(result) && $stable(flagN) && $stable(flagZ)));
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (flagZ == (result == 32'h0)));
  p_dst_index_r12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (dstIdx == $past(extWord[14:12])));
endmodule

bind bfx_unit bfx_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .extWord(extWord),
  .outValid(outValid), .wrEn(wrEn), .illegal(illegal), .dstIdx(dstIdx),
  .result(result), .flagN(flagN), .flagZ(flagZ)
);

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] opWord = '0, extWord = '0;
  logic [2:0] srcAddr, widAddr, ofsAddr, dstIdx;
  logic [31:0] srcData, widData, ofsData, result;
  logic outValid, wrEn, illegal, flagN, flagZ, flagV, flagC;
  logic [31:0] rf [8];

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign srcData = rf[srcAddr];
  assign widData = rf[widAddr];
  assign ofsData = rf[ofsAddr];

  bfx_unit dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-by-bit reference: returns {N,Z,V,C,result}
  function automatic logic [35:0] model(input logic [31:0] src, input int len,
                                        input int ofs, input bit sgn);
    logic [31:0] f = '0;
    for (int i = 0; i < len; i++) f[len-1-i] = src[(31 - ofs - i + 64) % 32];
    if (sgn) for (int j = len; j < 32; j++) f[j] = f[len-1];
    return {f[len-1], (f == 0 || (!sgn && f == 0)) && !(|f), 1'b0, 1'b0, f};
  endfunction

  // Drive one request at negedge, sample at the following negedge.
  task automatic issue(input logic [15:0] op, input logic [15:0] ex);
    @(negedge clk);
    opWord = op; extWord = ex; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sweep(input bit regW, input bit regO, input logic [31:0] pat, input string tag);
    for (int w = 0; w < 32; w++) begin
      for (int o = 0; o < 32; o++) begin
        bit sgn = ((w + o) % 2) == 1;
        int len = (w == 0) ? 32 : w;
        logic [15:0] op = sgn ? 16'hEBC1 : 16'hE9C1;
        logic [15:0] ex = 16'h5000;
        logic [35:0] e;
        rf[1] = pat;
        if (regW) begin ex[5] = 1'b1; ex[2:0] = 3'd3; ex[4:3] = 2'b11;
          rf[3] = 32'hABCDEF00 | 32'(w); end
        else ex[4:0] = 5'(w);
        if (regO) begin ex[11] = 1'b1; ex[8:6] = 3'd4; ex[10:9] = 2'b11;
          rf[4] = 32'h5A5A0000 | (32'(o) + 32'(((w + o) % 7) * 32)); end
        else ex[10:6] = 5'(o);
        issue(op, ex);
        e = model(pat, len, o, sgn);
        check($sformatf("%s w=%0d o=%0d s=%0d", tag, w, o, sgn),
              {27'b0, outValid, wrEn, illegal, dstIdx, flagN, flagZ, flagV, flagC, result},
              {27'b0, 1'b1, 1'b1, 1'b0, 3'd5, e});
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset", {56'b0, outValid, wrEn, illegal, flagN, flagZ, flagV, flagC, 1'b0} | {32'b0, result},
          64'h0);
    check("R11 reset dstIdx", {61'b0, dstIdx}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle no valid", {63'b0, outValid}, 64'h0);

    // R2 R3 R6 R7 R8 R12: immediate width and offset, wrapping fields included
    sweep(1'b0, 1'b0, 32'hC3A5_0F71, "R2/R3/R6/R7/R8 imm");
    // R4: width from register, upper junk ignored
    sweep(1'b1, 1'b0, 32'h8000_0001, "R4 regW");
    // R5: offset from register modulo 32
    sweep(1'b0, 1'b1, 32'h7E3C_91D4, "R5 regO");
    sweep(1'b1, 1'b1, 32'hFFFF_0000, "R4/R5 regWO");

    // R1 R10: illegal after a legal op holds result and flags
    rf[1] = 32'hF000_0000;
    issue(16'hEBC1, 16'h5104);   // signed, offset 4 width 4 -> all ones field? bits 27..24 = 0
    check("R7 signed zero field", {32'b0, result}, 64'h0);
    issue(16'hEBC1, 16'h5004);   // offset 0 width 4 -> 1111 signed
    check("R7 signed ones", {28'b0, flagN, flagZ, flagV, flagC, result}, {28'b0, 4'b1000, 32'hFFFF_FFFF});
    issue(16'hE8C1, 16'h2008);
    check("R1 illegal strobe", {61'b0, outValid, wrEn, illegal}, 64'h5);
    check("R10 hold", {28'b0, flagN, flagZ, flagV, flagC, result}, {28'b0, 4'b1000, 32'hFFFF_FFFF});
    check("R12 dst loaded on illegal", {61'b0, dstIdx}, 64'h2);
    issue(16'hE9C9, 16'h3004);   // bit 3 set -> not legal
    check("R1 illegal reg bits", {62'b0, wrEn, illegal}, 64'h1);
    issue(16'hE9C1, 16'h6004);   // zero-ext 4 bits at offset 0
    check("R7 unsigned", {32'b0, result}, 64'hF);
    check("R12 dst", {61'b0, dstIdx}, 64'h6);
    @(negedge clk);
    check("R9 valid drops", {62'b0, outValid, wrEn}, 64'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule